// File: doc/BRIEF.md
# Debug Trigger CSR Unit

This block holds the control and status registers of a single instruction-address breakpoint trigger, as seen by a debugger through the CSR space of a RISC-V core. It decodes CSR reads and writes aimed at the trigger address range. It stores three things: the trigger index the debugger selects, the trigger configuration word and the address to match. It also compares the current program counter against the stored address, so that the core can request a breakpoint.

Reads return data combinationally, in the same cycle as the request. Writes take effect at the next rising clock edge. Debug Mode may change the trigger configuration and the match address. Machine mode may access every register, but its writes to the trigger data registers have no effect. Any other privilege level, outside Debug Mode, gets an illegal-access indication. The select register clamps out-of-range values, so a debugger can find out how many triggers exist by reading it back. Three auxiliary trigger registers read as zero and discard writes.

Top module: `trig_csr_unit`

## Requirements
- R1: After the synchronous active-low reset, the select register (0x7A0) reads 0, the configuration register (0x7A1) reads 0x2800_1000 and the match-address register (0x7A2) reads 0.
- R2: A legal write to 0x7A0 stores the value when it is below the trigger count and stores the count minus one otherwise. With the default count of one, 0x7A0 always reads back 0.
- R3: A Debug-Mode write to 0x7A1 updates only bit 6 (machine-mode enable) and bit 2 (execute enable). Bits [31:28] read 2 (address-match type), bit 27 reads 1 (debug-only) and bits [15:12] read 1 (enter-debug action). All other bits read 0.
- R4: A Debug-Mode write to 0x7A2 stores the full 32-bit match address.
- R5: Writes to 0x7A1 and 0x7A2 made in machine mode outside Debug Mode leave both registers unchanged.
- R6: The registers at 0x7A3, 0x7A8 and 0x7AA read as zero, and writes to them change nothing.
- R7: An access to any trigger address with privilege below machine mode (privilege encoding 3 is machine, 1 is supervisor, 0 is user) while outside Debug Mode raises csrIllegal in that cycle, returns read data 0 and changes no register.
- R8: trigHit is high exactly when the execute enable is set, debugMode is low and pc equals the stored match address.
- R9: Read data reflects the register contents in the cycle of the request; a write becomes visible from the cycle after its clock edge.
- R10: A request to an address outside the trigger set drives csrIllegal low and read data 0, and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| csrReq | input | 1 | CSR access request valid |
| csrWe | input | 1 | Access is a write |
| csrAddr | input | 12 | CSR address |
| csrWdata | input | 32 | Write data |
| privLevel | input | 2 | Current privilege (3 machine, 1 supervisor, 0 user) |
| debugMode | input | 1 | Core is in Debug Mode |
| pc | input | 32 | Current instruction address |
| csrRdata | output | 32 | Read data, combinational |
| csrIllegal | output | 1 | Access refused for privilege |
| trigHit | output | 1 | Breakpoint match request |

## Verification
The hardest condition to reach from the ports is a hit: the execute enable must have been set by a Debug-Mode write, and then the core must leave Debug Mode with a pc equal to the 32-bit match address. Random addresses almost never produce this. The stimulus therefore makes half of its random pc values equal to the bench's copy of the match address, and it toggles debugMode and privilege on every access, so that both blocked and ignored writes come up often.

// File: rtl/trig_csr_pkg.sv
package trig_csr_pkg;

  localparam int unsigned XLEN = 32;

  localparam logic [11:0] ADDR_TSEL  = 12'h7A0;
  localparam logic [11:0] ADDR_TCFG  = 12'h7A1;
  localparam logic [11:0] ADDR_TADDR = 12'h7A2;
  localparam logic [11:0] ADDR_TZ0   = 12'h7A3;
  localparam logic [11:0] ADDR_TZ1   = 12'h7A8;
  localparam logic [11:0] ADDR_TZ2   = 12'h7AA;

  localparam logic [1:0] PRIV_M = 2'b11;

  // fixed part of the configuration word: type 2, debug-only, enter-debug action
  localparam logic [XLEN-1:0] CFG_FIXED = 32'h2800_1000;
  localparam int unsigned CFG_M_BIT    = 6;
  localparam int unsigned CFG_EXEC_BIT = 2;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_SEL,
    RD_CFG,
    RD_ADDR,
    RD_ZERO
  } rdSel_e;

  typedef struct packed {
    logic   selWr;
    logic   cfgWr;
    logic   addrWr;
    rdSel_e rdSel;
  } strobes_t;

endpackage

// File: rtl/trig_csr_ctrl.sv
module trig_csr_ctrl
  import trig_csr_pkg::*;
(
  input  logic        csrReq,
  input  logic        csrWe,
  input  logic [11:0] csrAddr,
  input  logic [1:0]  privLevel,
  input  logic        debugMode,
  output strobes_t    strobes,
  output logic        csrIllegal
);

  logic isSel, isCfg, isAddr, isZero, isTrig, allowed, doWrite;

  always_comb begin
    isSel   = (csrAddr == ADDR_TSEL);
    isCfg   = (csrAddr == ADDR_TCFG);
    isAddr  = (csrAddr == ADDR_TADDR);
    isZero  = (csrAddr == ADDR_TZ0) || (csrAddr == ADDR_TZ1) || (csrAddr == ADDR_TZ2);
    isTrig  = isSel || isCfg || isAddr || isZero;
    allowed = debugMode || (privLevel == PRIV_M);

    csrIllegal = csrReq && isTrig && !allowed;
    doWrite    = csrReq && csrWe && allowed;

    strobes.selWr  = doWrite && isSel;
    strobes.cfgWr  = doWrite && isCfg && debugMode;
    strobes.addrWr = doWrite && isAddr && debugMode;

    strobes.rdSel = RD_NONE;
    if (csrReq && allowed) begin
      if (isSel)       strobes.rdSel = RD_SEL;
      else if (isCfg)  strobes.rdSel = RD_CFG;
      else if (isAddr) strobes.rdSel = RD_ADDR;
      else if (isZero) strobes.rdSel = RD_ZERO;
    end
  end

endmodule

// File: rtl/trig_csr_dp.sv
module trig_csr_dp
  import trig_csr_pkg::*;
#(
  parameter int unsigned NUM_TRIG = 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobes_t        strobes,
  input  logic [XLEN-1:0] csrWdata,
  input  logic            debugMode,
  input  logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] csrRdata,
  output logic            trigHit,
  output logic [XLEN-1:0] selMatchAddr,
  output logic            selExec
);

  localparam int unsigned SEL_W = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;
  localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(NUM_TRIG - 1);

  logic [SEL_W-1:0] tselQ;
  logic [NUM_TRIG-1:0] execQ, mEnQ, slotHit, slotSel;
  logic [XLEN-1:0] matchQ [NUM_TRIG];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tselQ <= '0;
    end else if (strobes.selWr) begin
      if (csrWdata >= XLEN'(NUM_TRIG)) tselQ <= SEL_MAX;
      else                             tselQ <= csrWdata[SEL_W-1:0];
    end
  end

  for (genvar i = 0; i < NUM_TRIG; i++) begin : gSlot
    assign slotSel[i] = (tselQ == SEL_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        execQ[i]  <= 1'b0;
        mEnQ[i]   <= 1'b0;
        matchQ[i] <= '0;
      end else begin
        if (strobes.cfgWr && slotSel[i]) begin
          execQ[i] <= csrWdata[CFG_EXEC_BIT];
          mEnQ[i]  <= csrWdata[CFG_M_BIT];
        end
        if (strobes.addrWr && slotSel[i]) matchQ[i] <= csrWdata;
      end
    end

    assign slotHit[i] = execQ[i] && (pc == matchQ[i]);
  end

  assign trigHit = !debugMode && (|slotHit);

  logic [XLEN-1:0] cfgView;

  always_comb begin
    selMatchAddr = '0;
    selExec      = 1'b0;
    cfgView      = CFG_FIXED;
    for (int i = 0; i < NUM_TRIG; i++) begin
      if (slotSel[i]) begin
        selMatchAddr = matchQ[i];
        selExec      = execQ[i];
        cfgView[CFG_M_BIT]    = mEnQ[i];
        cfgView[CFG_EXEC_BIT] = execQ[i];
      end
    end
    unique case (strobes.rdSel)
      RD_SEL:  csrRdata = XLEN'(tselQ);
      RD_CFG:  csrRdata = cfgView;
      RD_ADDR: csrRdata = selMatchAddr;
      default: csrRdata = '0;
    endcase
  end

endmodule

// File: rtl/trig_csr_unit.sv
module trig_csr_unit
  import trig_csr_pkg::*;
#(
  parameter int unsigned NUM_TRIG = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csrReq,
  input  logic        csrWe,
  input  logic [11:0] csrAddr,
  input  logic [31:0] csrWdata,
  input  logic [1:0]  privLevel,
  input  logic        debugMode,
  input  logic [31:0] pc,
  output logic [31:0] csrRdata,
  output logic        csrIllegal,
  output logic        trigHit
);

  strobes_t        strobes;
  logic [XLEN-1:0] selMatchAddr;
  logic            selExec;

  trig_csr_ctrl uCtrl (
    .csrReq    (csrReq),
    .csrWe     (csrWe),
    .csrAddr   (csrAddr),
    .privLevel (privLevel),
    .debugMode (debugMode),
    .strobes   (strobes),
    .csrIllegal(csrIllegal)
  );

  trig_csr_dp #(.NUM_TRIG(NUM_TRIG)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .csrWdata    (csrWdata),
    .debugMode   (debugMode),
    .pc          (pc),
    .csrRdata    (csrRdata),
    .trigHit     (trigHit),
    .selMatchAddr(selMatchAddr),
    .selExec     (selExec)
  );

endmodule

// File: rtl/trig_csr_checker.sv
module trig_csr_checker
  import trig_csr_pkg::*;
#(
  parameter int unsigned NUM_TRIG = 1
) (
  input logic        clk,
  input logic        rstN,
  input logic        csrReq,
  input logic        csrWe,
  input logic [11:0] csrAddr,
  input logic [1:0]  privLevel,
  input logic        debugMode,
  input logic [31:0] pc,
  input logic [31:0] csrRdata,
  input logic        csrIllegal,
  input logic        trigHit,
  input logic [31:0] matchAddr,
  input logic        execEn
);

  logic inSet, zeroAddr;
  assign zeroAddr = (csrAddr == ADDR_TZ0) || (csrAddr == ADDR_TZ1) || (csrAddr == ADDR_TZ2);
  assign inSet = zeroAddr || (csrAddr == ADDR_TSEL) || (csrAddr == ADDR_TCFG) ||
                 (csrAddr == ADDR_TADDR);

  p_sel_in_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    (csrReq && csrAddr == ADDR_TSEL && !csrIllegal) |-> (csrRdata < NUM_TRIG));

  p_cfg_fixed_fields_r3: assert property (@(posedge clk) disable iff (!rstN)
    (csrReq && csrAddr == ADDR_TCFG && !csrIllegal) |->
      (csrRdata[31:28] == 4'd2 && csrRdata[27] && csrRdata[15:12] == 4'd1));

  p_mmode_write_ignored_r5: assert property (@(posedge clk) disable iff (!rstN)
    (csrReq && csrWe && !debugMode && csrAddr == ADDR_TADDR) |=> $stable(matchAddr));

  p_zero_regs_r6: assert property (@(posedge clk) disable iff (!rstN)
    (csrReq && zeroAddr) |-> (csrRdata == 32'd0));

  p_illegal_no_data_r7: assert property (@(posedge clk) disable iff (!rstN)
    csrIllegal |-> (csrRdata == 32'd0 && !debugMode && privLevel != PRIV_M));

  p_illegal_no_change_r7: assert property (@(posedge clk) disable iff (!rstN)
    csrIllegal |=> ($stable(matchAddr) && $stable(execEn)));

  p_hit_cond_r8: assert property (@(posedge clk) disable iff (!rstN)
    trigHit |-> (!debugMode && execEn && pc == matchAddr));

  p_outside_set_r10: assert property (@(posedge clk) disable iff (!rstN)
    (csrReq && !inSet) |-> (!csrIllegal && csrRdata == 32'd0));

endmodule

bind trig_csr_unit trig_csr_checker #(.NUM_TRIG(NUM_TRIG)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .csrReq    (csrReq),
  .csrWe     (csrWe),
  .csrAddr   (csrAddr),
  .privLevel (privLevel),
  .debugMode (debugMode),
  .pc        (pc),
  .csrRdata  (csrRdata),
  .csrIllegal(csrIllegal),
  .trigHit   (trigHit),
  .matchAddr (selMatchAddr),
  .execEn    (selExec)
);

// File: tb/test_trig_csr_unit.sv
module test_trig_csr_unit;

  logic        clk = 1'b0;
  logic        rstN;
  logic        csrReq, csrWe, debugMode;
  logic [11:0] csrAddr;
  logic [31:0] csrWdata, pc, csrRdata;
  logic [1:0]  privLevel;
  logic        csrIllegal, trigHit;

  int checks = 0;
  int fails  = 0;

  // bench model of the register contents
  logic        mExec, mMen;
  logic [31:0] mAddr;

  always #4 clk = ~clk;

  trig_csr_unit i_trig_csr_unit (
    .clk(clk), .rstN(rstN), .csrReq(csrReq), .csrWe(csrWe), .csrAddr(csrAddr),
    .csrWdata(csrWdata), .privLevel(privLevel), .debugMode(debugMode), .pc(pc),
    .csrRdata(csrRdata), .csrIllegal(csrIllegal), .trigHit(trigHit)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cfgWord();
    return 32'h2800_1000 | (32'(mMen) << 6) | (32'(mExec) << 2);
  endfunction

  function automatic logic isTrigAddr(input logic [11:0] a);
    return a == 12'h7A0 || a == 12'h7A1 || a == 12'h7A2 ||
           a == 12'h7A3 || a == 12'h7A8 || a == 12'h7AA;
  endfunction

  function automatic logic [31:0] expRead(input logic [11:0] a, input logic [1:0] p,
                                          input logic d);
    if (!(d || p == 2'b11)) return 32'd0;
    case (a)
      12'h7A1: return cfgWord();
      12'h7A2: return mAddr;
      default: return 32'd0;   // 7A0 clamps to 0 with one trigger, others zero
    endcase
  endfunction

  // one access: drive at negedge, check combinational outputs, apply at posedge
  task automatic access(input logic [11:0] a, input logic we, input logic [31:0] wd,
                        input logic [1:0] p, input logic d, input logic [31:0] pcv,
                        input string req);
    logic legal;
    @(negedge clk);
    csrReq = 1'b1; csrWe = we; csrAddr = a; csrWdata = wd;
    privLevel = p; debugMode = d; pc = pcv;
    #1;
    legal = d || p == 2'b11;
    chk({req, " R9 rdata"}, csrRdata, expRead(a, p, d));
    chk({req, " R7 illegal"}, 32'(csrIllegal), 32'(isTrigAddr(a) && !legal));
    chk({req, " R8 hit"}, 32'(trigHit), 32'(mExec && !d && pcv == mAddr));
    @(posedge clk);
    if (we && legal && d) begin
      if (a == 12'h7A1) begin mExec = wd[2]; mMen = wd[6]; end
      if (a == 12'h7A2) mAddr = wd;
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [11:0] addrs [6];
    void'($urandom(32'h5EED_1234));
    addrs = '{12'h7A0, 12'h7A1, 12'h7A2, 12'h7A3, 12'h7A8, 12'h7AA};
    mExec = 1'b0; mMen = 1'b0; mAddr = 32'd0;
    rstN = 1'b0; csrReq = 1'b0; csrWe = 1'b0; csrAddr = '0; csrWdata = '0;
    privLevel = 2'b11; debugMode = 1'b1; pc = 32'h0000_0004;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1 reset values
    access(12'h7A0, 0, 0, 2'b11, 1, 32'h4, "R1 sel");
    access(12'h7A1, 0, 0, 2'b11, 1, 32'h4, "R1 cfg");
    chk("R1 cfg value", csrRdata, 32'h2800_1000);
    access(12'h7A2, 0, 0, 2'b11, 1, 32'h4, "R1 addr");

    // R2 select clamp
    access(12'h7A0, 1, 32'd5, 2'b11, 0, 32'h4, "R2 write 5");
    access(12'h7A0, 0, 0, 2'b11, 0, 32'h4, "R2 readback");
    chk("R2 sel value", csrRdata, 32'd0);
    access(12'h7A0, 1, 32'hFFFF_FFFF, 2'b11, 1, 32'h4, "R2 write max");
    access(12'h7A0, 0, 0, 2'b11, 1, 32'h4, "R2 readback max");

    // R3 writable bits only
    access(12'h7A1, 1, 32'hFFFF_FFFF, 2'b11, 1, 32'h4, "R3 write ones");
    access(12'h7A1, 0, 0, 2'b11, 1, 32'h4, "R3 readback");
    chk("R3 cfg value", csrRdata, 32'h2800_1044);

    // R4 / R9 address write, old value visible before the edge
    access(12'h7A2, 1, 32'h8000_1234, 2'b11, 1, 32'h4, "R4 write");
    access(12'h7A2, 0, 0, 2'b11, 1, 32'h4, "R4 readback");
    chk("R4 addr value", csrRdata, 32'h8000_1234);

    // R5 machine-mode writes ignored
    access(12'h7A2, 1, 32'h0000_0001, 2'b11, 0, 32'h4, "R5 addr write");
    access(12'h7A1, 1, 32'h0, 2'b11, 0, 32'h4, "R5 cfg write");
    access(12'h7A2, 0, 0, 2'b11, 0, 32'h4, "R5 addr readback");
    chk("R5 addr value", csrRdata, 32'h8000_1234);
    access(12'h7A1, 0, 0, 2'b11, 0, 32'h4, "R5 cfg readback");

    // R6 zero registers
    foreach (addrs[k]) if (k >= 3) begin
      access(addrs[k], 1, 32'hFFFF_FFFF, 2'b11, 1, 32'h4, "R6 write");
      access(addrs[k], 0, 0, 2'b11, 1, 32'h4, "R6 read");
    end

    // R7 lower privilege
    access(12'h7A2, 1, 32'h1111_1111, 2'b00, 0, 32'h4, "R7 user write");
    access(12'h7A1, 1, 32'h0, 2'b01, 0, 32'h4, "R7 sup write");
    access(12'h7A2, 0, 0, 2'b11, 1, 32'h4, "R7 after");
    chk("R7 addr kept", csrRdata, 32'h8000_1234);

    // R10 unrelated address
    access(12'h300, 1, 32'hFFFF_FFFF, 2'b00, 0, 32'h4, "R10 other");
    access(12'h7A4, 0, 0, 2'b11, 1, 32'h4, "R10 near");

    // R8 hit corners
    access(12'h000, 0, 0, 2'b11, 0, 32'h8000_1234, "R8 match");
    chk("R8 hit high", 32'(trigHit), 32'd1);
    access(12'h000, 0, 0, 2'b11, 1, 32'h8000_1234, "R8 in debug");
    access(12'h000, 0, 0, 2'b11, 0, 32'h8000_1235, "R8 off by one");
    access(12'h7A1, 1, 32'h0, 2'b11, 1, 32'h4, "R8 disable");
    access(12'h000, 0, 0, 2'b11, 0, 32'h8000_1234, "R8 disabled");

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [11:0] a;
      logic [31:0] wd, pcv;
      logic [1:0]  p;
      a = ($urandom % 8 == 0) ? 12'($urandom) : addrs[$urandom % 6];
      wd = ($urandom % 2) ? $urandom : (32'h0000_0044 & $urandom);
      p = 2'($urandom);
      pcv = ($urandom % 2) ? mAddr : $urandom;
      access(a, 1'($urandom), wd, p, 1'($urandom), pcv, "rand R3 R4 R5 R7");
    end

    @(negedge clk); csrReq = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule